// File: doc/BRIEF.md
# Extended Register Address Decoder

This block connects a 32-bit register access port to a small interrupt controller register file. The port carries a request, a direction bit, an address, and a split 32-bit low and high data pair. The block decodes the address inside a 1024-entry window that starts at 800h. Each valid address selects one internal register, and data moves between that register and the low/high pair. Addresses that no register implements raise a fault.

The address map is compressed. Each 32-bit legacy register, placed every 16 bytes, takes one address: 800h plus the legacy offset divided by 16. The map has deliberate holes. The legacy destination-format register has no address here. The two legacy command words at 300h and 310h become one 64-bit register. A self-interrupt register exists only in this map. The block implements six registers:

| Address | Register | Access |
|---|---|---|
| 802h | identifier | read-only |
| 808h | task priority | read/write, 8 bits |
| 80Bh | end-of-interrupt sink | write-only |
| 80Dh | logical destination | read/write |
| 830h | command register | read/write, 64 bits |
| 83Fh | self-interrupt | write-only |

The block answers only while its extended-mode input is high. Every response arrives one cycle after its request.

Top module: `xreg_decoder`

## Requirements
- R1: Only addresses 802h, 808h, 80Bh, 80Dh, 830h and 83Fh are implemented. Any other address, whether inside 800h..BFFh or outside that window, gives `rsp_fault_o`=1.
- R2: Addresses 80Eh (legacy destination format) and 831h (upper half of the legacy command pair) always fault.
- R3: When `ext_mode_i` is 0 during a request, the access faults, whatever its address or direction.
- R4: `rsp_ready_o` is 1 in exactly the cycle after a cycle with `req_valid_i`=1, and 0 otherwise.
- R5: A successful read of a 32-bit register returns its value on `rd_lo_o` and zero on `rd_hi_o`.
- R6: The command register at 830h is 64 bits wide. A write stores `wr_lo_i` into bits 31:0 and `wr_hi_i` into bits 63:32. A read returns bits 31:0 on `rd_lo_o` and bits 63:32 on `rd_hi_o`.
- R7: A write to the logical destination register (80Dh) stores `wr_lo_i` and ignores `wr_hi_i`.
- R8: The task priority register (808h) keeps only bits 7:0 of a write. It reads back with bits 31:8 as zero.
- R9: The identifier (802h) reads as parameter LOCAL_ID. Writing to it faults.
- R10: Writes to 80Bh and 83Fh succeed with no fault. Reads of 80Bh and 83Fh fault.
- R11: A faulting access changes no register. A faulting access or any write returns zero on both read data words.
- R12: Reset sets the task priority, logical destination and command registers to zero, and holds `rsp_ready_o` and `rsp_fault_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode_i | input | 1 | Extended mode enable; the block answers only when this is 1 |
| req_valid_i | input | 1 | Access request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Register address |
| wr_lo_i | input | 32 | Write data, bits 31:0 |
| wr_hi_i | input | 32 | Write data, bits 63:32 (used by the command register only) |
| rsp_ready_o | output | 1 | Response valid, one cycle after the request |
| rsp_fault_o | output | 1 | The access was rejected |
| rd_lo_o | output | 32 | Read data, bits 31:0 |
| rd_hi_o | output | 32 | Read data, bits 63:32 |

## Verification
Two functions can land on the same clock edge: the register update of one access, and the address decode and read of the next access. Requests are issued back to back, with no idle cycle between them, so a read that follows a write to the same register samples the file on the edge right after the write commits. The bench must then see the new value, with task priority bits masked and the high word zero where the register is 32 bits. A mode toggle on the same request is also mixed in randomly, and an off-mode write is judged by a later read showing the register unchanged.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

  typedef enum logic [2:0] {
    RI_NONE = 3'd0,
    RI_ID   = 3'd1,
    RI_TPR  = 3'd2,
    RI_EOI  = 3'd3,
    RI_LDR  = 3'd4,
    RI_CMD  = 3'd5,
    RI_SELF = 3'd6
  } reg_idx_e;

  // One address per 16-byte legacy slot
  function automatic logic [31:0] legacy_to_addr(input logic [31:0] base,
                                                 input logic [31:0] legacy_off);
    return base + (legacy_off >> 4);
  endfunction

  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input logic [31:0] span);
    return (addr >= base) && (addr < base + span);
  endfunction

  // Access legality for a decoded register
  function automatic logic access_bad(input reg_idx_e idx, input logic wr);
    case (idx)
      RI_NONE:         return 1'b1;
      RI_ID:           return wr;
      RI_EOI, RI_SELF: return !wr;
      default:         return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xreg_addr_map.sv
module xreg_addr_map
  import xreg_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h800,
  parameter logic [31:0] WIN_SPAN  = 32'h400
) (
  input  logic        ext_mode,
  input  logic        is_write,
  input  logic [31:0] addr,
  output reg_idx_e    idx,
  output logic        fault
);
  localparam logic [31:0] A_ID   = legacy_to_addr(BASE_ADDR, 32'h020);
  localparam logic [31:0] A_TPR  = legacy_to_addr(BASE_ADDR, 32'h080);
  localparam logic [31:0] A_EOI  = legacy_to_addr(BASE_ADDR, 32'h0B0);
  localparam logic [31:0] A_LDR  = legacy_to_addr(BASE_ADDR, 32'h0D0);
  localparam logic [31:0] A_CMD  = legacy_to_addr(BASE_ADDR, 32'h300);
  localparam logic [31:0] A_SELF = legacy_to_addr(BASE_ADDR, 32'h3F0);

  logic hit_win;

  always_comb begin
    hit_win = in_window(addr, BASE_ADDR, WIN_SPAN);
    idx     = RI_NONE;
    if (hit_win) begin
      if      (addr == A_ID)   idx = RI_ID;
      else if (addr == A_TPR)  idx = RI_TPR;
      else if (addr == A_EOI)  idx = RI_EOI;
      else if (addr == A_LDR)  idx = RI_LDR;
      else if (addr == A_CMD)  idx = RI_CMD;
      else if (addr == A_SELF) idx = RI_SELF;
    end
    fault = !ext_mode || access_bad(idx, is_write);
  end
endmodule

// File: rtl/xreg_file.sv
module xreg_file
  import xreg_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          TPR_BITS = 8,
  parameter logic [31:0] LOCAL_ID = 32'h5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_idx_e      idx,
  input  logic [DW-1:0] wr_lo,
  input  logic [DW-1:0] wr_hi,
  output logic [DW-1:0] rd_lo,
  output logic [DW-1:0] rd_hi
);
  localparam int PAD = DW - TPR_BITS;

  logic [TPR_BITS-1:0] tpr_q;
  logic [DW-1:0]       ldr_q;
  logic [2*DW-1:0]     cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q <= '0;
      ldr_q <= '0;
      cmd_q <= '0;
    end else if (wr_en) begin
      case (idx)
        RI_TPR:  tpr_q <= wr_lo[TPR_BITS-1:0];
        RI_LDR:  ldr_q <= wr_lo;
        RI_CMD:  cmd_q <= {wr_hi, wr_lo};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    case (idx)
      RI_ID:   rd_lo = LOCAL_ID[DW-1:0];
      RI_TPR:  rd_lo = {{PAD{1'b0}}, tpr_q};
      RI_LDR:  rd_lo = ldr_q;
      RI_CMD:  {rd_hi, rd_lo} = cmd_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/xreg_decoder.sv
module xreg_decoder
  import xreg_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          TPR_BITS  = 8,
  parameter logic [31:0] BASE_ADDR = 32'h800,
  parameter logic [31:0] WIN_SPAN  = 32'h400,
  parameter logic [31:0] LOCAL_ID  = 32'h5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [31:0]   req_addr_i,
  input  logic [DW-1:0] wr_lo_i,
  input  logic [DW-1:0] wr_hi_i,
  output logic          rsp_ready_o,
  output logic          rsp_fault_o,
  output logic [DW-1:0] rd_lo_o,
  output logic [DW-1:0] rd_hi_o
);
  reg_idx_e      acc_idx;
  logic          acc_fault;
  logic          wr_commit;
  logic          rd_accept;
  logic [DW-1:0] file_lo, file_hi;

  xreg_addr_map #(.BASE_ADDR(BASE_ADDR), .WIN_SPAN(WIN_SPAN)) u_map (
    .ext_mode (ext_mode_i),
    .is_write (req_write_i),
    .addr     (req_addr_i),
    .idx      (acc_idx),
    .fault    (acc_fault)
  );

  assign wr_commit = req_valid_i && req_write_i && !acc_fault;
  assign rd_accept = req_valid_i && !req_write_i && !acc_fault;

  xreg_file #(.DW(DW), .TPR_BITS(TPR_BITS), .LOCAL_ID(LOCAL_ID)) u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_commit),
    .idx   (acc_idx),
    .wr_lo (wr_lo_i),
    .wr_hi (wr_hi_i),
    .rd_lo (file_lo),
    .rd_hi (file_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rd_lo_o     <= '0;
      rd_hi_o     <= '0;
    end else begin
      rsp_ready_o <= req_valid_i;
      rsp_fault_o <= req_valid_i && acc_fault;
      rd_lo_o     <= rd_accept ? file_lo : '0;
      rd_hi_o     <= rd_accept ? file_hi : '0;
    end
  end
endmodule

// File: rtl/xreg_checker.sv
module xreg_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_mode_i,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [31:0]   req_addr_i,
  input logic          rsp_ready_o,
  input logic          rsp_fault_o,
  input logic [DW-1:0] rd_lo_o,
  input logic [DW-1:0] rd_hi_o
);
  p_ready_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_ready_o);

  p_no_spurious_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_ready_o);

  p_mode_off_faults_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !ext_mode_i) |=> rsp_fault_o);

  p_hole_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (req_addr_i == 32'h80E || req_addr_i == 32'h831)) |=> rsp_fault_o);

  p_fault_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_o |-> (rd_lo_o == '0 && rd_hi_o == '0));

  p_id_write_faults_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_addr_i == 32'h802) |=> rsp_fault_o);

  p_sink_read_faults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && (req_addr_i == 32'h80B || req_addr_i == 32'h83F))
      |=> rsp_fault_o);

  p_narrow_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i != 32'h830) |=> (rd_hi_o == '0));

  p_tpr_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i == 32'h808) |=> (rd_lo_o[DW-1:8] == '0));
endmodule

bind xreg_decoder xreg_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_mode_i  (ext_mode_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .rsp_ready_o (rsp_ready_o),
  .rsp_fault_o (rsp_fault_o),
  .rd_lo_o     (rd_lo_o),
  .rd_hi_o     (rd_hi_o)
);

// File: tb/xreg_decoder_tb.sv
module xreg_decoder_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] MY_ID      = 32'h5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [31:0] wr_lo_i = '0;
  logic [31:0] wr_hi_i = '0;
  logic        rsp_ready_o, rsp_fault_o;
  logic [31:0] rd_lo_o, rd_hi_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench-side register state
  logic [7:0]  m_tpr = '0;
  logic [31:0] m_ldr = '0;
  logic [63:0] m_cmd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xreg_decoder #(.LOCAL_ID(MY_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i),
    .rsp_ready_o(rsp_ready_o), .rsp_fault_o(rsp_fault_o),
    .rd_lo_o(rd_lo_o), .rd_hi_o(rd_hi_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_fault(input bit ext, input bit wr, input logic [31:0] a);
    if (!ext) return 1'b1;
    case (a)
      32'h808, 32'h80D, 32'h830: return 1'b0;
      32'h802:                   return wr;
      32'h80B, 32'h83F:          return !wr;
      default:                   return 1'b1;
    endcase
  endfunction

  function automatic logic [63:0] exp_read(input logic [31:0] a);
    case (a)
      32'h802: return {32'h0, MY_ID};
      32'h808: return {56'h0, m_tpr};
      32'h80D: return {32'h0, m_ldr};
      32'h830: return m_cmd;
      default: return 64'h0;
    endcase
  endfunction

  function automatic string tag_of(input bit ext, input bit wr, input logic [31:0] a);
    if (!ext) return "R3";
    case (a)
      32'h80E, 32'h831: return "R2";
      32'h830:          return "R6";
      32'h802:          return "R9";
      32'h80B, 32'h83F: return "R10";
      32'h808:          return "R8";
      32'h80D:          return wr ? "R7" : "R5";
      default:          return "R1";
    endcase
  endfunction

  // Drive on a falling edge, check on the next falling edge.
  task automatic access(input bit ext, input bit wr, input logic [31:0] a,
                        input logic [31:0] lo, input logic [31:0] hi, input string tag);
    bit          f;
    logic [63:0] rexp;
    ext_mode_i  = ext;
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_addr_i  = a;
    wr_lo_i     = lo;
    wr_hi_i     = hi;
    f    = exp_fault(ext, wr, a);
    rexp = (f || wr) ? 64'h0 : exp_read(a);
    @(negedge clk);
    req_valid_i = 1'b0;
    check(tag, "ready", {63'h0, rsp_ready_o}, 64'h1);
    check(tag, "fault", {63'h0, rsp_fault_o}, {63'h0, f});
    check(tag, "rdata", {rd_hi_o, rd_lo_o}, rexp);
    if (!f && wr) begin
      case (a)
        32'h808: m_tpr = lo[7:0];
        32'h80D: m_ldr = lo;
        32'h830: m_cmd = {hi, lo};
        default: ;
      endcase
    end
  endtask

  task automatic idle(input string tag);
    req_valid_i = 1'b0;
    @(negedge clk);
    check(tag, "idle ready", {63'h0, rsp_ready_o}, 64'h0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "ready in reset", {63'h0, rsp_ready_o}, 64'h0);
    check("R12", "fault in reset", {63'h0, rsp_fault_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1, 0, 32'h808, 0, 0, "R12");
    access(1, 0, 32'h80D, 0, 0, "R12");
    access(1, 0, 32'h830, 0, 0, "R12");
    access(1, 0, 32'h802, 0, 0, "R9");
    idle("R4");
    // R6 both halves, then back-to-back read
    access(1, 1, 32'h830, 32'hDEAD_BEEF, 32'h1234_5678, "R6");
    access(1, 0, 32'h830, 0, 0, "R6");
    // R7 high word ignored
    access(1, 1, 32'h80D, 32'hA5A5_0001, 32'hFFFF_FFFF, "R7");
    access(1, 0, 32'h80D, 0, 0, "R7");
    // R8 masked priority
    access(1, 1, 32'h808, 32'hFFFF_FF3C, 32'h1, "R8");
    access(1, 0, 32'h808, 0, 0, "R8");
    // R9, R10
    access(1, 1, 32'h802, 32'h77, 0, "R9");
    access(1, 0, 32'h802, 0, 0, "R9");
    access(1, 1, 32'h80B, 32'h0, 0, "R10");
    access(1, 0, 32'h80B, 0, 0, "R10");
    access(1, 1, 32'h83F, 32'h41, 0, "R10");
    access(1, 0, 32'h83F, 0, 0, "R10");
    // R2 holes, R1 window edges and outside
    access(1, 0, 32'h80E, 0, 0, "R2");
    access(1, 1, 32'h831, 32'h9, 32'h9, "R2");
    access(1, 0, 32'h800, 0, 0, "R1");
    access(1, 0, 32'hBFF, 0, 0, "R1");
    access(1, 0, 32'hC00, 0, 0, "R1");
    access(1, 0, 32'h1830, 0, 0, "R1");
    // R3 / R11: off-mode write leaves state untouched
    access(0, 1, 32'h830, 32'h1111_1111, 32'h2222_2222, "R3");
    access(1, 0, 32'h830, 0, 0, "R11");
    access(1, 1, 32'h831, 32'h3, 32'h3, "R11");
    access(1, 0, 32'h830, 0, 0, "R11");
    idle("R4");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      int          k;
      bit          ext, wr;
      k   = $urandom % 10;
      ext = ($urandom % 8) != 0;
      wr  = $urandom % 2;
      case (k)
        0: a = 32'h802;
        1: a = 32'h808;
        2: a = 32'h80B;
        3: a = 32'h80D;
        4: a = 32'h830;
        5: a = 32'h83F;
        6: a = 32'h80E;
        7: a = 32'h831;
        8: a = 32'h800 + ($urandom % 1024);
        default: a = $urandom;
      endcase
      access(ext, wr, a, $urandom, $urandom, tag_of(ext, wr, a));
      if ($urandom % 16 == 0) idle("R4");
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule